// File: doc/BRIEF.md
# SCSI Block Move Sequencer

This block carries out a single block-move instruction on a parallel SCSI bus. It can act as the initiator or as the target. The instruction arrives already decoded, as four fields: a 3-bit phase, an opcode bit, a byte count and a start address. The bytes go between the bus and a byte-addressed memory port, 16 bits wide with byte enables. Memory reads are combinational.

As initiator, the block compares the requested phase with the phase on the bus. It starts only when the two agree, and on a mismatch it raises an interrupt and does nothing else. It then answers each REQ from the target with an ACK. As target, it drives the requested phase onto the bus and paces each byte with its own REQ. It also handles three bus rules:
- ATN drops on the last handshake of a message-out move.
- ACK stays asserted after the last message-in byte.
- On a 16-bit bus, an odd leftover byte is held and merged into the next move.

The phase code is {MSG, C/D, I/O}. Its bit 0 gives the direction, and 1 means toward the initiator. Data-out is 000, data-in 001, command 010, status 011, message-out 110 and message-in 111. The handshake pins are named for the role: `hs_out` is ACK as initiator and REQ as target, and `hs_in` is the peer's strobe.

Top module: `scsi_blkmove`

## Requirements
- R1: As initiator, if `ins_phase` differs from `bus_phase_in` when `start` is seen, `phase_irq` pulses for one cycle. No handshake, no memory write and no `done` follow, and the block stays idle.
- R2: When the phases match, exactly `ins_count` bytes move. Memory is touched only from `ins_addr` upward, and no other memory byte changes.
- R3: As target, `phase_oe` is high while a move runs, and `phase_out` equals the instruction phase and stays stable for the whole move.
- R4: With `wide_bus` low, each handshake carries one byte on lane [7:0]. On send, lane [15:8] is zero; on receive, lane [15:8] is ignored.
- R5: With `wide_bus` high, each handshake carries two bytes, with the lower-addressed byte on lane [7:0].
- R6: In a message-out move (110) as initiator with `atn_out` high, `atn_out` falls in the same cycle that `hs_out` rises for the last byte. It stays high on all earlier handshakes.
- R7: In a message-in move (111) as initiator, `hs_out` stays high after the last handshake until `clr_ack` is pulsed.
- R8: On a wide receive that ends on an odd byte with the opcode bit at 0, the final word's byte on lane [7:0] goes to memory. The byte on lane [15:8] is held and `res_valid` goes high.
- R9: On a wide send that ends on an odd byte with the opcode bit at 0, the final byte is read from memory and held without a handshake, and `res_valid` goes high.
- R10: A held byte merges into the next wide move in the same direction, and `res_valid` then clears. A held receive byte is written to the new start address first. A held send byte forms lane [7:0] of the first word, and the first memory byte forms lane [15:8].
- R11: With the opcode bit at 1, an odd wide tail holds nothing. On send, the last word carries the byte on [7:0] and zero on [15:8]. On receive, the byte on [15:8] is dropped.
- R12: A `flush_res` pulse clears `res_valid` on the next cycle, so no merge occurs afterwards.
- R13: `done` pulses for exactly one cycle when the count reaches zero. A count of zero gives `done` with no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin the instruction (ignored while busy) |
| tgt_mode | input | 1 | 1 = act as target, 0 = initiator |
| wide_bus | input | 1 | 1 = 16-bit bus, 0 = 8-bit |
| ins_phase | input | 3 | Requested phase {MSG,C/D,I/O} |
| ins_opc | input | 1 | Opcode bit; 0 keeps an odd wide tail byte |
| ins_count | input | CW | Byte count |
| ins_addr | input | AW | Start address |
| bus_phase_in | input | 3 | Latched bus phase seen by the initiator |
| set_atn | input | 1 | Assert ATN |
| clr_ack | input | 1 | Release a held ACK |
| flush_res | input | 1 | Discard the held residual byte |
| hs_in | input | 1 | Peer strobe (REQ as initiator, ACK as target) |
| hs_out | output | 1 | Own strobe (ACK as initiator, REQ as target) |
| atn_out | output | 1 | ATN line |
| phase_out | output | 3 | Phase driven as target |
| phase_oe | output | 1 | Phase output enable |
| sd_in | input | 16 | Bus data in |
| sd_out | output | 16 | Bus data out |
| sd_oe | output | 1 | Bus data output enable |
| mem_addr | output | AW | Memory byte address |
| mem_rdata | input | 16 | {byte at addr+1, byte at addr}, combinational |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte enables for mem_wdata |
| mem_wdata | output | 16 | Memory write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| phase_irq | output | 1 | One-cycle phase-mismatch pulse |
| res_valid | output | 1 | A residual byte is held |

## Verification
The hardest state to reach from the ports is a held residual byte that then meets a following move. Reaching it takes an odd-length wide move with the opcode bit at 0, and the next move must run in the same direction. The stimulus chains such moves in both directions with varied lengths, so a merge can itself leave a new tail behind. It also inserts a flush between two moves to show that the byte is lost. A bench model of the held byte carries over from one move to the next and predicts both the memory image and the bus words.

// File: rtl/scsi_blkmove.sv
`timescale 1ns/1ps
module scsi_blkmove #(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tgt_mode,
  input  logic          wide_bus,
  input  logic [2:0]    ins_phase,
  input  logic          ins_opc,
  input  logic [CW-1:0] ins_count,
  input  logic [AW-1:0] ins_addr,
  input  logic [2:0]    bus_phase_in,
  input  logic          set_atn,
  input  logic          clr_ack,
  input  logic          flush_res,
  input  logic          hs_in,
  output logic          hs_out,
  output logic          atn_out,
  output logic [2:0]    phase_out,
  output logic          phase_oe,
  input  logic [15:0]   sd_in,
  output logic [15:0]   sd_out,
  output logic          sd_oe,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  output logic          busy,
  output logic          done,
  output logic          phase_irq,
  output logic          res_valid
);
  typedef enum logic [1:0] {S_IDLE, S_NEXT, S_HS1, S_HS2} st_t;
  st_t st;

  logic [2:0]    ph_q;
  logic          opc_q, tgt_q, wide_q;
  logic [CW-1:0] cnt;
  logic [AW-1:0] adr;
  logic          strobe, ack_hold, atn, rs;
  logic [7:0]    rb;

  wire       rx       = tgt_q ? ~ph_q[0] : ph_q[0];
  wire       merge_tx = wide_q && res_valid && rs && !rx;
  wire       merge_rx = wide_q && res_valid && !rs && rx;
  wire [1:0] take     = (!wide_q || merge_tx || cnt < CW'(2)) ? 2'd1 : 2'd2;
  wire       last     = (cnt == CW'(take));
  wire       tail_tx  = wide_q && !rx && !opc_q && !merge_tx && cnt == CW'(1);
  wire       tail_rx  = wide_q && rx && !opc_q && cnt == CW'(1);
  wire       msg_out  = (ph_q == 3'b110);
  wire       msg_in   = (ph_q == 3'b111);
  wire       mism     = !tgt_mode && (ins_phase != bus_phase_in);
  wire       pre_wr   = (st == S_NEXT) && (cnt != '0) && merge_rx;

  assign busy      = (st != S_IDLE);
  assign hs_out    = strobe | ack_hold;
  assign atn_out   = atn;
  assign phase_out = ph_q;
  assign phase_oe  = busy && tgt_q;
  assign sd_oe     = busy && !rx;
  assign mem_addr  = adr;
  assign sd_out    = merge_tx   ? {mem_rdata[7:0], rb} :
                     take == 2  ? mem_rdata : {8'h00, mem_rdata[7:0]};
  assign mem_we    = pre_wr || ((st == S_HS1) && hs_in && rx);
  assign mem_be    = (pre_wr || take == 2'd1) ? 2'b01 : 2'b11;
  assign mem_wdata = pre_wr ? {8'h00, rb} : sd_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph_q <= '0; opc_q <= 1'b0; tgt_q <= 1'b0; wide_q <= 1'b0;
      cnt <= '0; adr <= '0; strobe <= 1'b0; ack_hold <= 1'b0; atn <= 1'b0;
      rs <= 1'b0; rb <= '0; res_valid <= 1'b0; done <= 1'b0; phase_irq <= 1'b0;
    end else begin
      done      <= 1'b0;
      phase_irq <= 1'b0;
      if (clr_ack) ack_hold <= 1'b0;
      if (set_atn) atn <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          if (mism) phase_irq <= 1'b1;
          else begin
            ph_q <= ins_phase; opc_q <= ins_opc; tgt_q <= tgt_mode;
            wide_q <= wide_bus; cnt <= ins_count; adr <= ins_addr;
            st <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (cnt == '0) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (merge_rx) begin
            cnt <= cnt - CW'(1); adr <= adr + AW'(1); res_valid <= 1'b0;
          end else if (tail_tx) begin
            rb <= mem_rdata[7:0]; rs <= 1'b1; res_valid <= 1'b1;
            cnt <= '0; adr <= adr + AW'(1);
          end else begin
            st <= S_HS1;
            if (tgt_q) strobe <= 1'b1;
          end
        end
        S_HS1: if (hs_in) begin
          if (!tgt_q) begin
            strobe <= 1'b1;
            if (msg_out && last) atn <= 1'b0;
          end else strobe <= 1'b0;
          if (tail_rx) begin
            rb <= sd_in[15:8]; rs <= 1'b0; res_valid <= 1'b1;
          end
          st <= S_HS2;
        end
        S_HS2: if (!hs_in) begin
          if (!tgt_q) begin
            strobe <= 1'b0;
            if (msg_in && last) ack_hold <= 1'b1;
          end
          if (merge_tx) res_valid <= 1'b0;
          cnt <= cnt - CW'(take);
          adr <= adr + AW'(take);
          st  <= S_NEXT;
        end
        default: st <= S_IDLE;
      endcase
      if (flush_res) res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_blkmove_chk.sv
`timescale 1ns/1ps
module scsi_blkmove_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       phase_irq,
  input logic       hs_out,
  input logic       atn_out,
  input logic       clr_ack,
  input logic       flush_res,
  input logic       res_valid,
  input logic       mem_we,
  input logic       phase_oe,
  input logic [2:0] phase_out
);
  a_r1_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    phase_irq |-> (!busy && !done));
  a_r2_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r3_phase_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oe && $past(phase_oe)) |-> $stable(phase_out));
  a_r6_atn_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(atn_out) |-> hs_out);
  a_r7_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hs_out && !clr_ack) |=> hs_out);
  a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_res |=> !res_valid);
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r13_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind scsi_blkmove scsi_blkmove_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .phase_irq(phase_irq),
  .hs_out(hs_out), .atn_out(atn_out), .clr_ack(clr_ack), .flush_res(flush_res),
  .res_valid(res_valid), .mem_we(mem_we), .phase_oe(phase_oe), .phase_out(phase_out)
);

// File: tb/scsi_blkmove_tb.sv
`timescale 1ns/1ps
module scsi_blkmove_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, start, tgt_mode, wide_bus, ins_opc, set_atn, clr_ack, flush_res, hs_in;
  logic [2:0] ins_phase, bus_phase_in, phase_out;
  logic [15:0] ins_count, ins_addr, mem_addr, sd_in, sd_out, mem_rdata, mem_wdata;
  logic hs_out, atn_out, phase_oe, sd_oe, mem_we, busy, done, phase_irq, res_valid;
  logic [1:0] mem_be;

  scsi_blkmove u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_mode(tgt_mode), .wide_bus(wide_bus),
    .ins_phase(ins_phase), .ins_opc(ins_opc), .ins_count(ins_count), .ins_addr(ins_addr),
    .bus_phase_in(bus_phase_in), .set_atn(set_atn), .clr_ack(clr_ack),
    .flush_res(flush_res), .hs_in(hs_in), .hs_out(hs_out), .atn_out(atn_out),
    .phase_out(phase_out), .phase_oe(phase_oe), .sd_in(sd_in), .sd_out(sd_out),
    .sd_oe(sd_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .busy(busy), .done(done),
    .phase_irq(phase_irq), .res_valid(res_valid)
  );

  logic [7:0] mem [256];
  logic [7:0] xm  [256];
  assign mem_rdata = {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
  always @(posedge clk) if (mem_we) begin
    if (mem_be[0]) mem[mem_addr[7:0]] <= mem_wdata[7:0];
    if (mem_be[1]) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
  end

  int done_cnt = 0, irq_cnt = 0, rise_cnt = 0;
  logic hs_prev = 1'b0;
  always @(posedge clk) begin
    hs_prev <= hs_out;
    if (done) done_cnt <= done_cnt + 1;
    if (phase_irq) irq_cnt <= irq_cnt + 1;
    if (hs_out && !hs_prev) rise_cnt <= rise_cnt + 1;
  end

  int total = 0, bad = 0;
  bit m_rv = 1'b0, m_rs = 1'b0;
  logic [7:0] m_rb = 8'h00;
  logic atnq [$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wait_hs(input logic v, output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 200; n++) begin
      if (hs_out === v) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic move(input bit tgt, input bit wd, input logic [2:0] ph, input bit opc,
                      input int cnt, input int adr, input int sd, input string rq);
    logic [15:0] hw [$];
    logic [15:0] w;
    int k, werr, d0, r0, me;
    bit rx, ok, allok;
    rx = tgt ? !ph[0] : ph[0];
    werr = 0; allok = 1'b1;
    for (int i = 0; i < 256; i++) begin
      mem[i] <= 8'(i * 5 + sd);
      xm[i] = 8'(i * 5 + sd);
    end
    k = 0;
    if (wd && cnt > 0 && m_rv && (m_rs == !rx)) begin
      if (rx) xm[adr & 255] = m_rb;
      else hw.push_back({xm[adr & 255], m_rb});
      k = 1; m_rv = 1'b0;
    end
    while (cnt - k > 0) begin
      w = 16'(sd * 771 + hw.size() * 4099 + 17);
      if (!wd) begin
        if (rx) xm[(adr + k) & 255] = w[7:0];
        else w = {8'h00, xm[(adr + k) & 255]};
        k++;
      end else if (cnt - k >= 2) begin
        if (rx) begin
          xm[(adr + k) & 255] = w[7:0]; xm[(adr + k + 1) & 255] = w[15:8];
        end else w = {xm[(adr + k + 1) & 255], xm[(adr + k) & 255]};
        k += 2;
      end else begin
        if (rx) begin
          xm[(adr + k) & 255] = w[7:0];
          if (!opc) begin m_rv = 1'b1; m_rb = w[15:8]; m_rs = 1'b0; end
        end else if (opc) w = {8'h00, xm[(adr + k) & 255]};
        else begin
          m_rv = 1'b1; m_rb = xm[(adr + k) & 255]; m_rs = 1'b1; k++;
          continue;
        end
        k++;
      end
      hw.push_back(w);
    end
    @(negedge clk);
    tgt_mode = tgt; wide_bus = wd; ins_phase = ph; ins_opc = opc;
    ins_count = 16'(cnt); ins_addr = 16'(adr); bus_phase_in = ph;
    d0 = done_cnt; r0 = rise_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < hw.size(); i++) begin
      if (!tgt) begin
        if (rx) sd_in = hw[i];
        hs_in = 1'b1;
        wait_hs(1'b1, ok); allok &= ok;
        if (!rx && sd_out !== hw[i]) werr++;
        atnq.push_back(atn_out);
        @(negedge clk);
        hs_in = 1'b0;
        if (!(ph == 3'b111 && i == hw.size() - 1)) begin wait_hs(1'b0, ok); allok &= ok; end
      end else begin
        wait_hs(1'b1, ok); allok &= ok;
        if (!phase_oe || phase_out !== ph) werr++;
        if (rx) sd_in = hw[i];
        else if (sd_out !== hw[i]) werr++;
        hs_in = 1'b1;
        wait_hs(1'b0, ok); allok &= ok;
        hs_in = 1'b0;
      end
      if (!allok) break;
    end
    for (int n = 0; n < 100 && busy; n++) @(negedge clk);
    @(negedge clk);
    chk(allok && werr == 0, {rq, " bus words / handshake"}, werr, 0);
    chk(rise_cnt - r0 == hw.size(), {rq, " handshake count"}, rise_cnt - r0, hw.size());
    chk(done_cnt == d0 + 1, {rq, " R13 done pulses"}, done_cnt - d0, 1);
    me = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== xm[i]) me++;
    chk(me == 0, {rq, " R2 memory image"}, me, 0);
    chk(res_valid == m_rv, {rq, " residue flag"}, res_valid, m_rv);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tgt_mode = 1'b0; wide_bus = 1'b0; ins_opc = 1'b1;
    set_atn = 1'b0; clr_ack = 1'b0; flush_res = 1'b0; hs_in = 1'b0;
    ins_phase = '0; bus_phase_in = '0; ins_count = '0; ins_addr = '0; sd_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !hs_out && !atn_out && !res_valid && !phase_oe && !done && !phase_irq,
        "reset state", {busy, hs_out, atn_out, res_valid, phase_oe}, 0);

    // R2 R4 R5 R11 R13: initiator sweep, opcode bit set
    for (int wd = 0; wd < 2; wd++)
      for (int dir = 0; dir < 2; dir++)
        for (int c = 0; c < 6; c++)
          move(1'b0, wd[0], {2'b00, dir[0]}, 1'b1, c, 40 + c, 3 * c + 11 * dir + wd,
               "R2/R4/R5/R11");

    // R3: target sweep
    for (int wd = 0; wd < 2; wd++)
      for (int dir = 0; dir < 2; dir++)
        for (int c = 1; c < 5; c++)
          move(1'b1, wd[0], {2'b00, dir[0]}, 1'b1, c, 90, 7 * c + dir, "R3 target");

    // R8 R10: receive residue chain
    move(1'b0, 1'b1, 3'b001, 1'b0, 3, 20, 5, "R8 rx odd tail");
    move(1'b0, 1'b1, 3'b001, 1'b0, 4, 60, 9, "R10 rx merge+tail");
    move(1'b0, 1'b1, 3'b001, 1'b1, 2, 70, 13, "R10 rx merge");
    // R9 R10: send residue chain
    move(1'b0, 1'b1, 3'b000, 1'b0, 5, 30, 21, "R9 tx odd tail");
    move(1'b0, 1'b1, 3'b000, 1'b0, 1, 50, 23, "R10 tx merge only");
    move(1'b0, 1'b1, 3'b000, 1'b0, 3, 80, 29, "R9 tx tail again");

    // R12: flush discards held byte
    @(negedge clk); flush_res = 1'b1;
    @(negedge clk); flush_res = 1'b0;
    chk(!res_valid, "R12 flush clears", res_valid, 0);
    m_rv = 1'b0;
    move(1'b0, 1'b1, 3'b000, 1'b1, 2, 100, 31, "R12 no merge after flush");

    // R6: ATN release on final message-out handshake
    @(negedge clk); set_atn = 1'b1;
    @(negedge clk); set_atn = 1'b0;
    chk(atn_out, "R6 atn set", atn_out, 1);
    atnq.delete();
    move(1'b0, 1'b0, 3'b110, 1'b1, 3, 10, 41, "R6 msg-out");
    chk(atnq.size() == 3 && atnq[0] && atnq[1] && !atnq[2], "R6 atn per handshake",
        atnq.size(), 3);
    chk(!atn_out, "R6 atn released", atn_out, 0);

    // R7: ACK held after message-in
    move(1'b0, 1'b0, 3'b111, 1'b1, 2, 12, 43, "R7 msg-in");
    repeat (5) @(negedge clk);
    chk(hs_out, "R7 ack held", hs_out, 1);
    clr_ack = 1'b1;
    @(negedge clk); clr_ack = 1'b0;
    @(negedge clk);
    chk(!hs_out, "R7 ack cleared", hs_out, 0);

    // R1: phase mismatch
    begin
      int i0, r0, d0, me;
      for (int i = 0; i < 256; i++) begin mem[i] <= 8'(i ^ 8'h3C); xm[i] = 8'(i ^ 8'h3C); end
      @(negedge clk);
      i0 = irq_cnt; r0 = rise_cnt; d0 = done_cnt;
      tgt_mode = 1'b0; wide_bus = 1'b1; ins_phase = 3'b001; bus_phase_in = 3'b011;
      ins_count = 16'd4; ins_addr = 16'd8; hs_in = 1'b1; sd_in = 16'hBEEF;
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      hs_in = 1'b0;
      chk(irq_cnt == i0 + 1, "R1 irq pulse", irq_cnt - i0, 1);
      chk(rise_cnt == r0 && done_cnt == d0 && !busy, "R1 no handshake/done",
          rise_cnt - r0, 0);
      me = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== xm[i]) me++;
      chk(me == 0, "R1 memory untouched", me, 0);
    end

    finish_up();
  end
endmodule